// File: doc/BRIEF.md
# Asynchronous Strobe-Acknowledge Host Slave

This block sits between a small microcontroller bus and a synchronous core. The host marks each register transfer with an active-low data strobe. It also provides a read/not-write line, a 3-bit register select and an 8-bit data bus. The block answers with an active-low acknowledge. The strobe is not related to the core clock. It is brought into the clock domain through a synchroniser chain. Each strobe pulse then turns into exactly one request to the core. The request carries the captured select, the transfer direction and the write byte.

The block holds acknowledge off until two conditions are both met: the core has reported completion, and a minimum hold-off has elapsed since the strobe was recognised. The hold-off gives the core time to arbitrate its internal buses. When acknowledge falls on a read, the read byte is put on the data bus in the same cycle. Acknowledge and the data drive stay on until the host drops the strobe. That completes a four-phase handshake. The data bus is split into an input byte, an output byte and an output enable, so that a pad cell can form the bidirectional pin.

The controller has four states:
- IDLE waits for the strobe.
- ISSUE holds the core request.
- SETTLE waits out the remaining hold-off.
- ACK holds acknowledge.

Its transitions are:
- IDLE→ISSUE, when the synchronised strobe is seen low.
- ISSUE→ACK, on completion with the hold-off already met.
- ISSUE→SETTLE, on completion with the hold-off still running.
- SETTLE→ACK, when the hold-off expires.
- ACK→IDLE, when the synchronised strobe is seen high.

Top module: `hostbus_slave`

## Requirements
- R1: While reset is held, and right after it, `host_ack_n` is 1, `host_dout_en` is 0 and `core_req` is 0.
- R2: Each low pulse of `host_stb_n` produces exactly one rising edge of `core_req`. The strobe passes through `SYNC_STAGES` flops before it is acted on.
- R3: While `core_req` is 1, `core_sel`, `core_rd` and `core_wdata` stay stable. They equal the `host_sel`, `host_rnw` and `host_din` that were present when the strobe was recognised. `host_rnw` = 1 means read and 0 means write, so `core_rd` = 1 marks a read. `core_req` stays 1 until `core_done` is sampled high.
- R4: `host_ack_n` stays 1 until `core_done` has been sampled. It falls no earlier than the clock edge that samples `core_done`.
- R5: `host_ack_n` falls no sooner than `MIN_HOLD` clock edges after the edge at which `core_req` rises. `MIN_HOLD` is at least 1.
- R6: On a read, in the cycle `host_ack_n` falls, `host_dout_en` is 1 and `host_dout` equals the `core_rdata` that was present with `core_done`.
- R7: On a write, `host_dout_en` stays 0 for the whole access.
- R8: `host_ack_n` stays 0, and on a read `host_dout_en` stays 1, for as long as the host holds the strobe low. After the strobe rises, `host_ack_n` returns to 1 and `host_dout_en` to 0 within `SYNC_STAGES`+2 clock edges.
- R9: No new core request is raised while `host_ack_n` is 0. A strobe held low for a long time still yields a single access. A fresh strobe after release yields a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_stb_n | input | 1 | Host data strobe, active low, asynchronous |
| host_rnw | input | 1 | Host direction: 1 read, 0 write |
| host_sel | input | SEL_W | Host register select |
| host_din | input | DATA_W | Host data bus, inbound byte |
| host_dout | output | DATA_W | Host data bus, outbound byte |
| host_dout_en | output | 1 | Output enable for the host data bus |
| host_ack_n | output | 1 | Acknowledge to the host, active low |
| core_req | output | 1 | Access request to the core, held until done |
| core_sel | output | SEL_W | Captured register select |
| core_rd | output | 1 | Captured direction, 1 for read |
| core_wdata | output | DATA_W | Captured write byte |
| core_done | input | 1 | Core completion pulse |
| core_rdata | input | DATA_W | Read byte, valid with `core_done` |

## Verification
Writes and reads are run against a core that completes at once. In that case the hold-off alone decides when acknowledge falls (R5). They are also run against a core that answers seven cycles late, which shows that completion rather than the hold-off governs acknowledge (R4). A strobe held low for many cycles separates "acknowledge lasts as long as the strobe" from a fixed-length acknowledge. The same test shows whether a lingering strobe would raise a second request. Back-to-back transfers with different selects, bytes and directions show that capture is fresh on every access and that data drive is confined to reads.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    // Handshake controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // waiting for the host strobe
        ST_ISSUE  = 2'd1,   // request held towards the core
        ST_SETTLE = 2'd2,   // core done, hold-off still running
        ST_ACK    = 2'd3    // acknowledge driven, waiting for strobe release
    } hbs_state_e;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {N{RST_VAL}};
        end else begin
            chain_q <= {chain_q[N-2:0], d_async};
        end
    end

    assign q_sync = chain_q[N-1];

endmodule

// File: rtl/hbs_capture.sv
module hbs_capture #(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              rcap_en,
    input  logic              host_rnw,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [DATA_W-1:0] host_din,
    input  logic [DATA_W-1:0] core_rdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic              rnw_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Request fields, taken once per strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            rnw_q   <= 1'b0;
            wdata_q <= '0;
        end else if (load_en) begin
            sel_q   <= host_sel;
            rnw_q   <= host_rnw;
            wdata_q <= host_din;
        end
    end

    // Read byte, taken with the completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rcap_en) begin
            rdata_q <= core_rdata;
        end
    end

    // R3: the fields may only be reloaded after the previous capture was
    // followed by a quiet cycle without load
    p_no_double_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);

endmodule

// File: rtl/hbs_fsm.sv
module hbs_fsm
    import hbs_pkg::*;
#(
    parameter int MIN_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_on,     // synchronised strobe asserted
    input  logic core_done,
    input  logic rnw_q,
    output logic load_en,
    output logic rcap_en,
    output logic core_req,
    output logic ack_n,
    output logic dout_en
);
    localparam int HOLD_EFF  = (MIN_HOLD < 1) ? 1 : MIN_HOLD;
    localparam int CW        = $clog2(HOLD_EFF + 1);
    localparam int HOLD_LAST = HOLD_EFF - 1;

    hbs_state_e state_q, state_d;
    logic [CW-1:0] hold_q;
    logic          hold_ok;
    logic          got_done_q;

    assign hold_ok = (hold_q == HOLD_LAST[CW-1:0]);
    assign load_en = (state_q == ST_IDLE) && stb_on;
    assign rcap_en = (state_q == ST_ISSUE) && core_done;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stb_on) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (core_done) state_d = hold_ok ? ST_ACK : ST_SETTLE;
            end
            ST_SETTLE: begin
                if (hold_ok) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (!stb_on) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Hold-off counter from strobe recognition, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_en) begin
            hold_q <= '0;
        end else if (!hold_ok) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // Completion seen during this access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_done_q <= 1'b0;
        end else if (load_en) begin
            got_done_q <= 1'b0;
        end else if (rcap_en) begin
            got_done_q <= 1'b1;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_req <= 1'b0;
            ack_n    <= 1'b1;
            dout_en  <= 1'b0;
        end else begin
            core_req <= (state_d == ST_ISSUE);
            ack_n    <= (state_d != ST_ACK);
            dout_en  <= (state_d == ST_ACK) && rnw_q;
        end
    end

    // R4: acknowledge never falls before completion was taken
    p_ack_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> got_done_q);

    // R5: acknowledge falls only once the hold-off has run out
    p_ack_holdoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> hold_ok);

    // R3: request persists until completion arrives
    p_req_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_done) |=> core_req);

    // R8: acknowledge held while the strobe stays low
    p_ack_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && stb_on) |=> !ack_n);

    // R7: data drive only within a read acknowledge
    p_drive_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ack_n && rnw_q));

    // R9: no request while acknowledge is low
    p_no_req_in_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !core_req);

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
    parameter int SEL_W       = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HOLD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb_n,
    input  logic              host_rnw,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_dout_en,
    output logic              host_ack_n,
    output logic              core_req,
    output logic [SEL_W-1:0]  core_sel,
    output logic              core_rd,
    output logic [DATA_W-1:0] core_wdata,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_rdata
);
    logic stb_n_sync;
    logic stb_on;
    logic load_en;
    logic rcap_en;
    logic rnw_q;
    logic [DATA_W-1:0] rdata_q;

    hbs_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_stb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (host_stb_n),
        .q_sync  (stb_n_sync)
    );

    assign stb_on = !stb_n_sync;

    hbs_fsm #(
        .MIN_HOLD (MIN_HOLD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_on    (stb_on),
        .core_done (core_done),
        .rnw_q     (rnw_q),
        .load_en   (load_en),
        .rcap_en   (rcap_en),
        .core_req  (core_req),
        .ack_n     (host_ack_n),
        .dout_en   (host_dout_en)
    );

    hbs_capture #(
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .rcap_en    (rcap_en),
        .host_rnw   (host_rnw),
        .host_sel   (host_sel),
        .host_din   (host_din),
        .core_rdata (core_rdata),
        .sel_q      (core_sel),
        .rnw_q      (rnw_q),
        .wdata_q    (core_wdata),
        .rdata_q    (rdata_q)
    );

    assign core_rd   = rnw_q;
    assign host_dout = rdata_q;

    // R3: request fields stable across a held request
    p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && $past(core_req)) |-> ($stable(core_sel) && $stable(core_wdata) && $stable(core_rd)));

    // R6: when a read acknowledge starts, the bus is driven
    p_read_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_ack_n) && core_rd) |-> host_dout_en);

endmodule

// File: tb/test_hostbus_slave.sv
`timescale 1ns/1ps
module test_hostbus_slave;
    localparam int SEL_W    = 3;
    localparam int DATA_W   = 8;
    localparam int SYNC_ST  = 2;
    localparam int MIN_HOLD = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_stb_n = 1'b1;
    logic              host_rnw = 1'b1;
    logic [SEL_W-1:0]  host_sel = '0;
    logic [DATA_W-1:0] host_din = '0;
    logic [DATA_W-1:0] host_dout;
    logic              host_dout_en;
    logic              host_ack_n;
    logic              core_req;
    logic [SEL_W-1:0]  core_sel;
    logic              core_rd;
    logic [DATA_W-1:0] core_wdata;
    logic              core_done = 1'b0;
    logic [DATA_W-1:0] core_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int core_delay = 0;
    logic [DATA_W-1:0] core_answer = '0;
    int req_count = 0;
    logic [SEL_W-1:0]  last_sel = '0;
    logic              last_rd = 1'b0;
    logic [DATA_W-1:0] last_wdata = '0;

    hostbus_slave #(
        .SEL_W(SEL_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_ST), .MIN_HOLD(MIN_HOLD)
    ) i_hostbus_slave (
        .clk(clk), .rst_n(rst_n),
        .host_stb_n(host_stb_n), .host_rnw(host_rnw), .host_sel(host_sel),
        .host_din(host_din), .host_dout(host_dout), .host_dout_en(host_dout_en),
        .host_ack_n(host_ack_n), .core_req(core_req), .core_sel(core_sel),
        .core_rd(core_rd), .core_wdata(core_wdata), .core_done(core_done),
        .core_rdata(core_rdata)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // Core model: answers each request after core_delay cycles
    initial begin
        forever begin
            @(negedge clk);
            if (core_req) begin
                req_count++;
                last_sel   = core_sel;
                last_rd    = core_rd;
                last_wdata = core_wdata;
                repeat (core_delay) @(negedge clk);
                core_done  = 1'b1;
                core_rdata = core_answer;
                @(negedge clk);
                core_done  = 1'b0;
                core_rdata = '0;
                while (core_req) @(negedge clk);
            end
        end
    end

    // One full four-phase transfer with checks
    task automatic host_cycle(input logic rnw, input logic [SEL_W-1:0] sel,
                              input logic [DATA_W-1:0] wb, input int dly,
                              input int extra, input logic [DATA_W-1:0] rb);
        int req_cyc;
        int ack_cyc;
        int n;
        int reqs0;
        int need;
        core_delay  = dly;
        core_answer = rb;
        reqs0       = req_count;
        @(negedge clk);
        host_rnw = rnw;
        host_sel = sel;
        host_din = wb;
        #2 host_stb_n = 1'b0;
        req_cyc = -1;
        n = 0;
        while (host_ack_n && n < 200) begin
            @(negedge clk);
            n++;
            if (core_req && req_cyc < 0) req_cyc = cyc;
            if (!host_ack_n) break;
        end
        ack_cyc = cyc;
        chk(host_ack_n == 1'b0, "R4 ack asserted", int'(host_ack_n), 0);
        need = (MIN_HOLD > dly + 1) ? MIN_HOLD : dly + 1;
        // R5 for a fast core, R4 for a slow one
        chk(req_cyc >= 0 && (ack_cyc - req_cyc) >= need,
            (dly + 1 >= MIN_HOLD) ? "R4 ack waits for done" : "R5 ack hold-off",
            ack_cyc - req_cyc, need);
        chk(last_sel == sel && last_rd == rnw, "R3 captured select/direction",
            int'({last_rd, last_sel}), int'({rnw, sel}));
        if (rnw) begin
            chk(host_dout_en == 1'b1, "R6 drive on read ack", int'(host_dout_en), 1);
            chk(host_dout == rb, "R6 read byte", int'(host_dout), int'(rb));
        end else begin
            chk(host_dout_en == 1'b0, "R7 no drive on write", int'(host_dout_en), 0);
            chk(last_wdata == wb, "R3 write byte", int'(last_wdata), int'(wb));
        end
        host_din = ~wb;
        for (int i = 0; i < extra; i++) begin
            @(negedge clk);
            chk(host_ack_n == 1'b0 && host_dout_en == rnw, "R8 ack held with strobe",
                int'({host_ack_n, host_dout_en}), int'({1'b0, rnw}));
        end
        host_stb_n = 1'b1;
        n = 0;
        while (!host_ack_n && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(host_ack_n == 1'b1 && n <= SYNC_ST + 2, "R8 release latency", n, SYNC_ST + 2);
        chk(host_dout_en == 1'b0, "R8 drive released", int'(host_dout_en), 0);
        chk(req_count == reqs0 + 1, "R2 one request per strobe", req_count - reqs0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(host_ack_n == 1'b1 && host_dout_en == 1'b0 && core_req == 1'b0,
            "R1 in reset", int'({host_ack_n, host_dout_en, core_req}), 4);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(host_ack_n == 1'b1 && host_dout_en == 1'b0 && core_req == 1'b0,
            "R1 after reset", int'({host_ack_n, host_dout_en, core_req}), 4);
    endtask

    task automatic t_fast();
        host_cycle(1'b0, 3'd1, 8'hA5, 0, 0, 8'h00);
        host_cycle(1'b1, 3'd5, 8'h00, 0, 0, 8'h3C);
    endtask

    task automatic t_slow();
        host_cycle(1'b1, 3'd3, 8'h00, 7, 0, 8'hC3);
        host_cycle(1'b0, 3'd4, 8'h5A, 7, 0, 8'h00);
    endtask

    task automatic t_long_strobe();
        // R9: long strobe gives one access only
        host_cycle(1'b1, 3'd2, 8'h00, 1, 20, 8'h81);
        host_cycle(1'b0, 3'd6, 8'hFF, 0, 15, 8'h00);
    endtask

    task automatic t_back_to_back();
        // R9: each fresh strobe after release yields a new access
        host_cycle(1'b0, 3'd7, 8'h01, 0, 0, 8'h00);
        host_cycle(1'b1, 3'd0, 8'h00, 2, 0, 8'h7E);
        host_cycle(1'b0, 3'd1, 8'h80, 3, 2, 8'h00);
    endtask

    task automatic t_idle_quiet();
        // R9: no request while no strobe is present
        int r0;
        r0 = req_count;
        repeat (20) @(negedge clk);
        chk(req_count == r0 && host_ack_n == 1'b1, "R9 quiet without strobe", req_count - r0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_fast();
        t_slow();
        t_long_strobe();
        t_back_to_back();
        t_idle_quiet();
        finish_run();
    end

endmodule